// File: doc/BRIEF.md
# Memory-Mapped Configuration Access Translator

This block lets a big-endian processor reach the configuration space of a little-endian peripheral interconnect through a plain 4 MB memory window. A request whose address falls in the window is claimed. Its offset is then folded into a compact configuration address. The low 11 offset bits are kept as they are. The one-hot device-select field above them becomes a 4-bit device number. Data wider than a byte is byte-reversed on the way out and again on the way back. The request then goes to a simple configuration port. That port carries a size code, a write flag and a one-cycle read-return handshake.

The same block also holds the interrupt swizzle for the slots. Each slot has four interrupt pins. Each pin lands on one of two internal lines, chosen by the pin number plus the slot's device number. Those two lines drive two host interrupt outputs, named after host inputs 9 and 11.

Top module: `cfg_window_xlate`

## Requirements
- R1: An access is claimed (`req_claim` high) only when `req_addr` lies in the window from 0x8080_0000 through 0x80BF_FFFF. An unclaimed access never produces `cfg_valid`.
- R2: Offset bits 10:0 appear unchanged in `cfg_addr[10:0]`.
- R3: `cfg_addr[14:11]` holds the index (0 to 10) of the lowest set bit among offset bits 21:11. Offset bit 11 is index 0.
- R4: When offset bits 21:11 are all zero, `cfg_addr[14:11]` is 11.
- R5: With size code 0 (byte), write data and read data pass through unchanged.
- R6: With size code 1 (half-word), the result is `{16'h0, d[7:0], d[15:8]}`. This applies to write data toward the port and to read data back to the processor.
- R7: With size code 2 (word), all four bytes are reversed in both directions. Byte 0 moves to byte 3, byte 1 to byte 2, and so on.
- R8: A claimed access that is accepted raises `cfg_valid` for exactly one cycle on the next clock, carrying the address, `cfg_we`, `cfg_size` and data. A read's `cfg_rvalid` raises `rsp_valid` with the swapped `cfg_rdata` on the following clock, for one cycle.
- R9: While a read is outstanding, `req_stall` is high and no new request is issued. The read counts as outstanding from the clock after it is accepted until its `cfg_rvalid`.
- R10: The slot pins are indexed as `slot_pins[4*s+p]`, where p=0..3 is the pin. Pin p of slot s belongs to line (p+s) mod 2. `irq_host11` is the OR of the line-1 pins and `irq_host9` is the OR of the line-0 pins, each registered with one cycle of latency.
- R11: Synchronous active-high `rst` drops any outstanding read and clears `cfg_valid`, `rsp_valid` and both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | 32 | Processor byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Big-endian write data |
| req_claim | output | 1 | Address lies inside the window |
| req_stall | output | 1 | A read is outstanding; requests are not taken |
| rsp_valid | output | 1 | Read data returned to the processor |
| rsp_rdata | output | 32 | Swapped read data |
| cfg_valid | output | 1 | Configuration request, one cycle |
| cfg_we | output | 1 | Configuration write flag |
| cfg_size | output | 2 | Size code of the request |
| cfg_addr | output | 15 | Device number in bits 14:11, offset in bits 10:0 |
| cfg_wdata | output | 32 | Little-endian write data |
| cfg_rvalid | input | 1 | Read data from the configuration port is valid |
| cfg_rdata | input | 32 | Little-endian read data |
| slot_pins | input | 16 | Interrupt pins, four per slot |
| irq_host9 | output | 1 | Host interrupt line 0 |
| irq_host11 | output | 1 | Host interrupt line 1 |

## Verification
The hardest state to reach is a request that arrives while a read is still open. It has to be refused without being lost or issued. The bench makes the configuration target answer after a random delay of zero to three cycles. During that gap it offers fresh in-window requests and checks that nothing goes out. It also covers a reply on the very cycle of the issue, and a reset that lands in the middle of an open read. For device numbers, the bench mixes offsets with an empty select field, with a single set bit, and with several set bits, so that the "lowest bit wins" rule and the value-11 fallback are both exercised.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // Endian conversion: byte passes, half-word swaps its two bytes, word reverses all four.
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    case (sz)
      2'd0:    r = d;
      2'd1:    r = {16'h0000, d[7:0], d[15:8]};
      default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfgw_addr_map.sv
module cfgw_addr_map #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_W = 22,
  parameter int LOW_W = 11,
  localparam int SEL_W = WIN_W - LOW_W,
  localparam int DEV_W = $clog2(SEL_W + 1),
  localparam int OUT_W = LOW_W + DEV_W
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [DEV_W-1:0] dev_num,
  output logic [OUT_W-1:0] cfg_addr
);
  logic [SEL_W-1:0] sel_field;

  // Index of the lowest set bit; SEL_W when the field is empty.
  function automatic logic [DEV_W-1:0] lowest_one(input logic [SEL_W-1:0] s);
    logic [DEV_W-1:0] r;
    r = DEV_W'(SEL_W);
    for (int i = SEL_W - 1; i >= 0; i--)
      if (s[i]) r = DEV_W'(i);
    return r;
  endfunction

  assign hit       = (addr[31:WIN_W] == WIN_BASE[31:WIN_W]);
  assign sel_field = addr[WIN_W-1:LOW_W];
  assign dev_num   = lowest_one(sel_field);
  assign cfg_addr  = {dev_num, addr[LOW_W-1:0]};
endmodule

// File: rtl/cfgw_irq_route.sv
module cfgw_irq_route #(
  parameter int NUM_SLOTS = 4,
  parameter int PINS_PER_SLOT = 4,
  parameter int SLOT_BASE = 0,
  localparam int NPIN = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins,
  output logic            irq_line0,
  output logic            irq_line1
);
  logic [NPIN-1:0] line0_mask, line1_mask;
  logic line0_any, line1_any;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
      localparam int LINE = (p + s + SLOT_BASE) % 2;
      assign line1_mask[s*PINS_PER_SLOT+p] = (LINE == 1);
      assign line0_mask[s*PINS_PER_SLOT+p] = (LINE == 0);
    end
  end

  assign line0_any = |(pins & line0_mask);
  assign line1_any = |(pins & line1_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line0 <= 1'b0;
      irq_line1 <= 1'b0;
    end else begin
      irq_line0 <= line0_any;
      irq_line1 <= line1_any;
    end
  end

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !(|$past(pins)) |-> (!irq_line0 && !irq_line1));
  p_irq_src0_r10: assert property (@(posedge clk) disable iff (rst)
    irq_line0 |-> $past(line0_any));
  p_irq_src1_r10: assert property (@(posedge clk) disable iff (rst)
    irq_line1 |-> $past(line1_any));
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfgw_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_W = 22,
  parameter int LOW_W = 11,
  parameter int NUM_SLOTS = 4,
  parameter int PINS_PER_SLOT = 4,
  localparam int DEV_W = $clog2(WIN_W - LOW_W + 1),
  localparam int OUT_W = LOW_W + DEV_W,
  localparam int NPIN = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_claim,
  output logic              req_stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cfg_valid,
  output logic              cfg_we,
  output logic [1:0]        cfg_size,
  output logic [OUT_W-1:0]  cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rvalid,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [NPIN-1:0]   slot_pins,
  output logic              irq_host9,
  output logic              irq_host11
);
  logic             win_hit;
  logic [DEV_W-1:0] dev_num;
  logic [OUT_W-1:0] xl_addr;
  logic             accept;
  logic             rd_pending;
  logic             rd_return;

  cfgw_addr_map #(.WIN_BASE(WIN_BASE), .WIN_W(WIN_W), .LOW_W(LOW_W)) u_map (
    .addr(req_addr), .hit(win_hit), .dev_num(dev_num), .cfg_addr(xl_addr)
  );

  cfgw_irq_route #(.NUM_SLOTS(NUM_SLOTS), .PINS_PER_SLOT(PINS_PER_SLOT)) u_irq (
    .clk(clk), .rst(rst), .pins(slot_pins),
    .irq_line0(irq_host9), .irq_line1(irq_host11)
  );

  assign req_claim = win_hit;
  assign req_stall = rd_pending;
  assign accept    = req_valid && win_hit && !rd_pending;
  assign rd_return = cfg_rvalid && rd_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid  <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_size   <= SZ_BYTE;
      cfg_addr   <= '0;
      cfg_wdata  <= '0;
      rd_pending <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      cfg_valid <= accept;
      if (accept) begin
        cfg_addr  <= xl_addr;
        cfg_we    <= req_we;
        cfg_size  <= req_size;
        cfg_wdata <= lane_swap(req_wdata, req_size);
      end
      if (accept && !req_we) rd_pending <= 1'b1;
      else if (rd_return)    rd_pending <= 1'b0;
      rsp_valid <= rd_return;
      // cfg_size still describes the outstanding read: nothing is accepted meanwhile.
      if (rd_return) rsp_rdata <= lane_swap(cfg_rdata, cfg_size);
    end
  end

  p_issue_in_window_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> $past(req_valid && req_claim && !req_stall));
  p_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));
  p_dev_range_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_addr[OUT_W-1:LOW_W] <= DEV_W'(WIN_W - LOW_W)));
  p_word_rev_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_size == SZ_WORD) |->
      (cfg_wdata == {$past(req_wdata[7:0]), $past(req_wdata[15:8]),
                     $past(req_wdata[23:16]), $past(req_wdata[31:24])}));
  p_rsp_after_ret_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cfg_rvalid && req_stall));
  p_no_issue_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $past(req_stall) |-> !cfg_valid);
endmodule

// File: tb/tb_cfg_window_xlate.sv
`timescale 1ns/1ps
module tb_cfg_window_xlate;
  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_we, req_claim, req_stall, rsp_valid;
  logic [31:0] req_addr, req_wdata, rsp_rdata, cfg_wdata, cfg_rdata;
  logic [1:0] req_size, cfg_size;
  logic cfg_valid, cfg_we, cfg_rvalid;
  logic [14:0] cfg_addr;
  logic [15:0] slot_pins;
  logic irq_host9, irq_host11;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cfg_window_xlate dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dev(input logic [31:0] a);
    int k;
    k = 0;
    while (k < 11 && a[11+k] == 1'b0) k++;
    return 4'(k);
  endfunction

  function automatic logic [31:0] exp_conv(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    r = 32'h0;
    if (sz == 2'd0) r = d;
    else if (sz == 2'd1) begin
      r[15:8] = d[7:0];
      r[7:0]  = d[15:8];
    end else
      for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [1:0] exp_irq(input logic [15:0] p);
    logic [1:0] r;
    r = 2'b00;
    for (int s = 0; s < 4; s++)
      for (int q = 0; q < 4; q++)
        if (p[4*s+q]) r[(q+s)%2] = 1'b1;
    return r;
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_addr = 0; req_we = 0; req_size = 0; req_wdata = 0;
    cfg_rvalid = 0; cfg_rdata = 0;
  endtask

  // One access; delay = cycles before the target answers a read.
  task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] rd, input int delay);
    bit inwin;
    logic [14:0] ea;
    inwin = (a >= 32'h8080_0000) && (a <= 32'h80BF_FFFF);
    ea = {exp_dev(a), a[10:0]};
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = we; req_size = sz; req_wdata = wd;
    #1;
    chk(req_claim == inwin, "R1 claim", 32'(req_claim), 32'(inwin));
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!inwin) begin
      chk(cfg_valid == 0, "R1 no issue outside window", 32'(cfg_valid), 0);
      return;
    end
    chk(cfg_valid == 1, "R8 issue", 32'(cfg_valid), 1);
    chk(cfg_addr[10:0] == ea[10:0], "R2 low bits", 32'(cfg_addr), 32'(ea));
    chk(cfg_addr[14:11] == ea[14:11],
        (ea[14:11] == 4'd11) ? "R4 empty select" : "R3 device number",
        32'(cfg_addr), 32'(ea));
    chk(cfg_we == we && cfg_size == sz, "R8 attributes", {cfg_we, cfg_size}, {we, sz});
    if (we) begin
      chk(cfg_wdata == exp_conv(wd, sz),
          sz == 0 ? "R5 write" : (sz == 1 ? "R6 write" : "R7 write"),
          cfg_wdata, exp_conv(wd, sz));
      return;
    end
    for (int i = 0; i < delay; i++) begin
      chk(req_stall == 1, "R9 stall", 32'(req_stall), 1);
      req_valid = 1; req_addr = 32'h8080_0000 | 32'($urandom_range(0, 32'h3F_FFFF));
      req_we = 1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(cfg_valid == 0, "R9 no issue while busy", 32'(cfg_valid), 0);
    end
    cfg_rvalid = 1; cfg_rdata = rd;
    @(posedge clk);
    @(negedge clk);
    cfg_rvalid = 0;
    chk(rsp_valid == 1, "R8 response", 32'(rsp_valid), 1);
    chk(rsp_rdata == exp_conv(rd, sz),
        sz == 0 ? "R5 read" : (sz == 1 ? "R6 read" : "R7 read"),
        rsp_rdata, exp_conv(rd, sz));
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 0 && req_stall == 0, "R8 single response", {rsp_valid, req_stall}, 0);
  endtask

  function automatic logic [31:0] rnd_win_addr();
    logic [21:0] off;
    int mode;
    mode = $urandom_range(0, 2);
    off[10:0] = 11'($urandom);
    if (mode == 0) off[21:11] = 0;
    else if (mode == 1) off[21:11] = 11'(1) << $urandom_range(0, 10);
    else off[21:11] = 11'($urandom);
    return 32'h8080_0000 + 32'(off);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    slot_pins = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(cfg_valid == 0 && rsp_valid == 0 && req_stall == 0, "R11 reset state",
        {cfg_valid, rsp_valid, req_stall}, 0);
    chk(irq_host9 == 0 && irq_host11 == 0, "R11 irq reset", {irq_host9, irq_host11}, 0);

    // Directed corners
    access(32'h8080_0123, 1, 2'd2, 32'h1122_3344, 0, 0);        // R4, R7
    access(32'h80BF_FFFF, 1, 2'd1, 32'hAABB_CCDD, 0, 0);        // R3 bit 11 set
    access(32'h80A0_0007, 0, 2'd0, 0, 32'hDEAD_BEEF, 2);        // R3 index 10, R5
    access(32'h807F_FFFF, 1, 2'd2, 32'h1, 0, 0);                // R1 below
    access(32'h80C0_0000, 0, 2'd1, 0, 32'h1, 0);                // R1 above
    access(32'h8080_4000, 0, 2'd1, 0, 32'h0000_1234, 0);        // R6 read, same-cycle reply

    // Reset during an open read (R11)
    @(negedge clk);
    req_valid = 1; req_addr = 32'h8080_0800; req_we = 0; req_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_stall == 1, "R9 read open", 32'(req_stall), 1);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(req_stall == 0 && cfg_valid == 0, "R11 pending dropped", {req_stall, cfg_valid}, 0);
    cfg_rvalid = 1; cfg_rdata = 32'h55;
    @(posedge clk);
    @(negedge clk);
    cfg_rvalid = 0;
    chk(rsp_valid == 0, "R11 stray return ignored", 32'(rsp_valid), 0);

    // Random accesses
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = ($urandom_range(0, 7) == 0) ? ($urandom() ^ 32'h8000_0000 ^ 32'h0100_0000) : rnd_win_addr();
      if (a[31:22] == 10'h202) a[31:22] = 10'h203;
      if ($urandom_range(0, 7) != 0) a = rnd_win_addr();
      access(a, 1'($urandom), 2'($urandom_range(0, 2)), $urandom(), $urandom(),
             $urandom_range(0, 3));
    end

    // Interrupt routing (R10)
    for (int n = 0; n < 200; n++) begin
      logic [15:0] p;
      logic [1:0] e;
      case (n)
        0: p = 16'h0000;
        1: p = 16'h0001;
        2: p = 16'h0010;
        3: p = 16'hA5A5;
        4: p = 16'h5A5A;
        default: p = ($urandom_range(0, 1) == 0) ? (16'(1) << $urandom_range(0, 15)) : 16'($urandom);
      endcase
      e = exp_irq(p);
      @(negedge clk);
      slot_pins = p;
      @(posedge clk);
      @(negedge clk);
      chk({irq_host11, irq_host9} == e, "R10 irq routing", {irq_host11, irq_host9}, 32'(e));
    end
    slot_pins = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk(irq_host9 == 0 && irq_host11 == 0, "R11 irq cleared", {irq_host9, irq_host11}, 0);
    rst = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule